// File: doc/BRIEF.md
# Pseudo-Random Video Test Pattern Generator

This block produces one 24-bit test pixel on every pixel clock for a three-channel serial video link. The pixel is split into three 8-bit channel bytes. A one-bit mode input selects the test pattern.

- **Half-clock pattern.** Every channel carries the same byte. The byte alternates between 0x01 and 0xFF, which gives a low-frequency waveform for checking signal levels, edge rates and lane skew.
- **Pseudo-random pattern.** The channels carry adjacent slices of a 23-bit maximal-length shift-register sequence, so each channel sees a different phase of the same stream.

The pseudo-random sequence restarts from a fixed seed at a fixed point in frame timing. A remote checker that applies the same restart rule stays in lock-step with the generator. The restart point is the first rising edge of the data-enable strobe after a vertical sync pulse.

The frame timing strobes come from elsewhere. A one-cycle-delayed copy of the data-enable strobe is output, and the data register lines up with that copy.

Top module: `tpg_video_pattern`

## Requirements
- R1: While `rst` is sampled high, the next edge clears `pix_o` to 0 and `de_o` to 0.
- R2: In pseudo-random mode the shift-register state `s` is 23 bits wide, and the new bit is `s[22]^s[4]`, which implements x^23 + x^5 + 1. The pixel is the 24-bit value `{new bit, s}`, with channel 2 in `pix_o[23:16]`, channel 1 in `pix_o[15:8]` and channel 0 in `pix_o[7:0]`. On consecutive running pixels, `pix_o[22:0]` equals the previous `{pix_o[21:0], pix_o[23]}`, and `pix_o[23] == pix_o[22]^pix_o[4]`.
- R3: At a reseed edge in pseudo-random mode, the pixel written is 0x000001, and the next pixel is 0x000002.
- R4: A reseed edge needs three things: `de` is 1 at this edge, `de` was 0 at the previous edge, and the generator is armed. Arming happens at an edge where `vsync` is sampled high. A `de` rising edge with no earlier `vsync` does not reseed.
- R5: A reseed disarms the generator. Further `de` rising edges do not reseed until `vsync` is seen again.
- R6: From reset until the first reseed, pseudo-random pixels stay at 0x000001 and the register does not advance.
- R7: Half-clock pixels are 0x010101 or 0xFFFFFF, with all channels equal. They alternate from one half-clock pixel to the next, and the first one after reset is 0x010101. The phase advances only on half-clock pixels.
- R8: A change of `mode_sel` affects the pixel written at the next edge. Once reseeded, the shift register advances on every clock in either mode.
- R9: The shift-register state is never all zeros.
- R10: `de_o` equals `de` delayed by one edge. The seeded pixel appears in the same cycle as the rise of `de_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = half-clock pattern, 1 = pseudo-random pattern |
| vsync | input | 1 | Vertical sync strobe, arms the reseed |
| de | input | 1 | Data-enable strobe; its rising edge reseeds when armed |
| pix_o | output | 24 | Registered pixel, channel 2 in the top byte |
| de_o | output | 1 | `de` delayed by one clock |

## Verification
The bench covers four kinds of risky event:
- `de` rising edges that arrive with no earlier `vsync`. A design that reseeds on any `de` edge jumps back to 0x000001 there.
- `vsync` and a `de` rise on the same edge. A design that arms and loads in the same cycle reseeds one line too early.
- A second line in the same frame. A design missing the disarm step restarts the sequence on every line, which a remote checker would see as loss of lock.
- Mode switches in both directions. A design that freezes the register during half-clock mode resumes the sequence at the wrong phase, and one that starts on 0xFF breaks the first-byte rule.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_PRBS = 1'b1
  } tpg_mode_e;
endpackage

// File: rtl/tpg_frame_sync.sv
module tpg_frame_sync (
  input  logic clk,
  input  logic rst,
  input  logic vsync,
  input  logic de,
  output logic load_o,
  output logic de_dly_o
);
  logic de_q;
  logic armed_q;

  // Reseed event: an armed rising edge of DE.
  assign load_o   = armed_q & de & ~de_q;
  assign de_dly_o = de_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      de_q    <= de;
      armed_q <= ~load_o & (armed_q | vsync);
    end
  end

  // R5: after a reseed, DE is high, so no rising edge exists one cycle later.
  assert_single_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

  // R10: the delayed strobe follows the input one edge later.
  assert_de_delay_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> de_dly_o == $past(de));
endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int             W    = 23,
  parameter int             TAP  = 5,
  parameter logic [W-1:0]   SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  output logic         run_o,
  output logic [W:0]   tap_vec_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] src;
  logic         run_q;

  function automatic logic fb_of(input logic [W-1:0] s);
    return s[W-1] ^ s[TAP-1];
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], fb_of(s)};
  endfunction

  // Source of the current pixel: the seed on a reseed edge, else the live state.
  assign src       = load ? SEED : state_q;
  assign tap_vec_o = {fb_of(src), src};
  assign run_o     = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
      run_q   <= 1'b0;
    end else if (load) begin
      state_q <= step(SEED);
      run_q   <= 1'b1;
    end else if (run_q) begin
      state_q <= step(state_q);
    end
  end

  assert_no_zero_state_R9: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  assert_hold_seed_R6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load) |=> state_q == SEED);
endmodule

// File: rtl/tpg_half.sv
module tpg_half #(
  parameter int              CH_W   = 8,
  parameter logic [CH_W-1:0] BYTE_A = 8'h01,
  parameter logic [CH_W-1:0] BYTE_B = 8'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [CH_W-1:0] byte_o
);
  logic ph_q;

  assign byte_o = ph_q ? BYTE_B : BYTE_A;

  always_ff @(posedge clk) begin
    if (rst)      ph_q <= 1'b0;
    else if (adv) ph_q <= ~ph_q;
  end

  assert_half_toggle_R7: assert property (@(posedge clk) disable iff (rst)
    adv |=> byte_o != $past(byte_o));
endmodule

// File: rtl/tpg_video_pattern.sv
module tpg_video_pattern #(
  parameter int                  CH_W   = 8,
  parameter int                  N_CH   = 3,
  parameter int                  LFSR_W = 23,
  parameter int                  TAP    = 5,
  parameter logic [LFSR_W-1:0]   SEED   = 23'h000001,
  parameter logic [CH_W-1:0]     HALF_A = 8'h01,
  parameter logic [CH_W-1:0]     HALF_B = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mode_sel,
  input  logic                   vsync,
  input  logic                   de,
  output logic [N_CH*CH_W-1:0]   pix_o,
  output logic                   de_o
);
  import tpg_pkg::*;

  localparam int PIX_W = N_CH * CH_W;

  tpg_mode_e           mode;
  logic                prbs;
  logic                load_w;
  logic                run_w;
  logic [LFSR_W:0]     tap_vec;
  logic [CH_W-1:0]     half_byte;
  logic [PIX_W-1:0]    pix_d;
  logic                prev_prbs_q;

  assign mode = tpg_mode_e'(mode_sel);
  assign prbs = (mode == MODE_PRBS);

  tpg_frame_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .vsync    (vsync),
    .de       (de),
    .load_o   (load_w),
    .de_dly_o (de_o)
  );

  tpg_lfsr #(.W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk       (clk),
    .rst       (rst),
    .load      (load_w),
    .run_o     (run_w),
    .tap_vec_o (tap_vec)
  );

  tpg_half #(.CH_W(CH_W), .BYTE_A(HALF_A), .BYTE_B(HALF_B)) u_half (
    .clk    (clk),
    .rst    (rst),
    .adv    (!prbs),
    .byte_o (half_byte)
  );

  // Per-channel select between the tap slice and the shared half-clock byte.
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assign pix_d[ch*CH_W +: CH_W] = prbs ? tap_vec[ch*CH_W +: CH_W] : half_byte;
    if (ch > 0) begin : g_eq
      assert_channels_equal_R7: assert property (@(posedge clk) disable iff (rst)
        !prbs |=> pix_o[ch*CH_W +: CH_W] == pix_o[CH_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o       <= '0;
      prev_prbs_q <= 1'b0;
    end else begin
      pix_o       <= pix_d;
      prev_prbs_q <= prbs;
    end
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (prbs && prev_prbs_q && run_w && !load_w) |=>
      pix_o[PIX_W-2:0] == {$past(pix_o[PIX_W-3:0]), $past(pix_o[PIX_W-1])});

  assert_feedback_R2: assert property (@(posedge clk) disable iff (rst)
    prbs |=> pix_o[PIX_W-1] == (pix_o[PIX_W-2] ^ pix_o[TAP-1]));

  assert_seed_first_R3: assert property (@(posedge clk) disable iff (rst)
    (load_w && prbs) |=> pix_o[LFSR_W-1:0] == SEED);

  assert_mode_effect_R8: assert property (@(posedge clk) disable iff (rst)
    !prbs |=> (pix_o[CH_W-1:0] == HALF_A) || (pix_o[CH_W-1:0] == HALF_B));
endmodule

// File: tb/tb_tpg_video_pattern.sv
`timescale 1ns/1ps
module tb_tpg_video_pattern;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vs  = 1'b0;
  logic        de  = 1'b0;
  logic        md  = 1'b1;
  logic [23:0] pix;
  logic        de_o;

  always #2.5 clk = ~clk;

  tpg_video_pattern dut (
    .clk(clk), .rst(rst), .mode_sel(md), .vsync(vs), .de(de),
    .pix_o(pix), .de_o(de_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string tag    = "R1";

  // Reference model, built from the requirement text.
  logic [22:0] m_s;
  logic        m_armed, m_run, m_ph, m_deq;
  logic [23:0] e_pix;
  logic        e_de;

  function automatic logic newbit(input logic [22:0] s);
    return s[22] ^ s[4];
  endfunction

  function automatic logic [23:0] pixel_of(input logic [22:0] s);
    return {newbit(s), s};
  endfunction

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Called at a falling edge: drive inputs, advance the model, check after the next rising edge.
  task automatic cyc(input logic r, input logic v, input logic d, input logic m);
    logic ld;
    rst = r; vs = v; de = d; md = m;
    if (r) begin
      m_s = 23'h1; m_armed = 0; m_run = 0; m_ph = 0; m_deq = 0;
      e_pix = '0; e_de = 0;
    end else begin
      ld = m_armed && d && !m_deq;
      if (m) e_pix = pixel_of(ld ? 23'h1 : m_s);
      else   e_pix = {3{(m_ph ? 8'hFF : 8'h01)}};
      if (!m) m_ph = ~m_ph;
      if (ld)         m_s = {22'h1, newbit(23'h1)};
      else if (m_run) m_s = {m_s[21:0], newbit(m_s)};
      if (ld) m_run = 1;
      m_armed = !ld && (m_armed || v);
      m_deq   = d;
      e_de    = d;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, pix, e_pix);
    chk("R10", {23'h0, de_o}, {23'h0, e_de});
    if (!r && m) begin
      chk("R2", {23'h0, pix[23]}, {23'h0, pix[22] ^ pix[4]});
      n_chk++;
      if (pix[22:0] == 23'h0) begin
        n_fail++;
        $display("FAIL R9: actual %h expected nonzero state", pix);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1);
    chk("R1", pix, 24'h0);

    // R6 hold seed; R4 DE edges without VSYNC do not reseed
    tag = "R4";
    for (int i = 0; i < 8; i++) cyc(0, 0, i[1], 1);
    chk("R6", pix, 24'h000001);

    // Arm, gap, then reseed
    tag = "R6";
    cyc(0, 1, 0, 1); cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
    chk("R6", pix, 24'h000001);
    tag = "R3";
    cyc(0, 0, 1, 1);
    chk("R3", pix, 24'h000001);
    chk("R10", {23'h0, de_o}, 24'h1);
    cyc(0, 0, 1, 1);
    chk("R3", pix, 24'h000002);
    tag = "R2";
    for (int i = 0; i < 300; i++) cyc(0, 0, 1, 1);

    // R5 second line without VSYNC continues the sequence
    tag = "R5";
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1);

    // R7 / R8 switch to half-clock mode, first byte 0x01
    tag = "R8";
    cyc(0, 0, 1, 0);
    chk("R7", pix, 24'h010101);
    tag = "R7";
    cyc(0, 0, 1, 0);
    chk("R7", pix, 24'hFFFFFF);
    for (int i = 0; i < 11; i++) cyc(0, 0, 1, 0);
    tag = "R8";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1);

    // VSYNC and DE rise on the same edge while unarmed: arms only
    tag = "R4";
    cyc(0, 0, 0, 1);
    cyc(0, 1, 1, 1);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 1, 1);
    chk("R3", pix, 24'h000001);

    // Frames with mixed modes
    tag = "R5";
    for (int f = 0; f < 20; f++) begin
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, (f % 3) != 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, (f % 3) != 0);
      for (int l = 0; l < 10; l++) begin
        for (int i = 0; i < 64; i++) cyc(0, 0, 1, (f % 3) != 0 || l > 4);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1);
      end
    end

    // Reset mid-run returns to the held-seed state
    tag = "R1";
    cyc(1, 0, 1, 1); cyc(1, 0, 1, 1);
    chk("R1", pix, 24'h0);
    tag = "R6";
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], 1);
    chk("R6", pix, 24'h000001);
    finish_run();
  end
endmodule